// File: doc/BRIEF.md
# Smooth Digital Clock Calibration Unit

This block trims the rate of a calendar that runs from a slow reference clock, nominally 32768 Hz. It sits between that clock and the first prescaler stage. On every reference clock cycle it tells the prescaler how far to advance: zero steps when a pulse is removed, one step normally, and two steps when a pulse is added. Removing pulses slows the calendar and adding pulses speeds it up. One pulse per full window is worth about 0.95 ppm.

The trim is applied over a calibration window of 2^WIN_LOG2 cycles, which is 32 s at the default size. A 9-bit minus count sets how many pulses are removed per full window. A plus bit adds 512 pulses per full window. Two select bits can shorten the window to one half or one quarter of its length. The removed and added pulses are spread evenly over the window. Each window is cut into 512 slots. The first cycle of a slot is a candidate, and the bit-reversed slot index is compared against the count, so no pulses are removed in a burst. A shorter window ignores the low bits of the minus count, so the trim per second stays the same. A new setting is captured only when a window ends.

Top module: `smooth_cal_unit`

## Requirements
- R1: After a synchronous reset the window counter is zero and the active setting is cleared. `adv_o` is 1 on every cycle of the first full window (sum 2^WIN_LOG2), whatever the inputs are.
- R2: With the plus bit and both select bits low, a window lasts 2^WIN_LOG2 cycles. The sum of `adv_o` over the window is 2^WIN_LOG2 minus `calm_i`.
- R3: Candidate cycles are the first cycle of each of the 512 equal slots. A slot whose 9-bit index, bit-reversed, is below the count is masked. With `calm_i` = 256 the first half of a full window therefore holds exactly 128 masked cycles.
- R4: With `plus_i` = 1 every slot's first cycle gains one inserted pulse. A full window then sums to 2^WIN_LOG2 + 512 − `calm_i`.
- R5: `adv_o` encodes 0 = masked, 1 = normal and 2 = inserted, and never takes the value 3. A cycle that is both masked and inserted gives 1. With `calm_i` = 511 and plus set, a full window has exactly one 2, no 0, and sums to 2^WIN_LOG2 + 1.
- R6: With `win16_i` = 1 the window is 2^(WIN_LOG2−1) cycles and bit 0 of the count is taken as 0. The window masks (count with bit 0 cleared)/2 pulses and inserts 256 when plus is set.
- R7: With `win8_i` = 1 the window is 2^(WIN_LOG2−2) cycles and bits 1:0 of the count are taken as 0. The window masks (count with bits 1:0 cleared)/4 pulses and inserts 128 when plus is set.
- R8: When both select bits are 1, the quarter window of R7 applies.
- R9: Changes to `calm_i`, `plus_i`, `win8_i` or `win16_i` take effect only from the first cycle of the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one cycle per raw pulse |
| rst_n | input | 1 | Synchronous reset, active low |
| calm_i | input | 9 | Pulses to remove per full window |
| plus_i | input | 1 | Insert 512 pulses per full window |
| win8_i | input | 1 | Select the quarter-length window (has priority) |
| win16_i | input | 1 | Select the half-length window |
| adv_o | output | 2 | Prescaler advance for this cycle: 0, 1 or 2 |

## Verification
Removal and insertion can both fall on the first cycle of the same slot when the plus bit is set and the slot's reversed index is below the count. With a count of 511 and the plus bit set, 511 of the 512 slot starts carry both actions. The bench checks that those cycles give 1 and that only the top slot gives 2, using a per-window count of 0s and 2s and the window sum. The half-window and quarter-window cases with plus set produce the same overlap on a shorter window, and their window sums are compared against the formulas above.

// File: rtl/smooth_cal_pkg.sv
// Package: shared types and helpers for the smooth calibration unit.
// Assumes a fixed 512-slot spreading grid (9-bit trim count).
package smooth_cal_pkg;

    localparam int SLOT_BITS = 9;
    localparam int NUM_SLOTS = 1 << SLOT_BITS;

    // Window length choice: full, half or quarter of the nominal window.
    typedef enum logic [1:0] {
        WIN_FULL    = 2'd0,
        WIN_HALF    = 2'd1,
        WIN_QUARTER = 2'd2
    } win_sel_e;

    // Setting in force for the current window.
    typedef struct packed {
        logic [SLOT_BITS-1:0] calm;
        logic                 plus;
        win_sel_e             sel;
    } cal_cfg_t;

    // Reverse the bit order of a slot index so that consecutive counts land far apart.
    function automatic logic [SLOT_BITS-1:0] bit_rev(input logic [SLOT_BITS-1:0] v);
        logic [SLOT_BITS-1:0] r;
        for (int i = 0; i < SLOT_BITS; i++) begin
            r[i] = v[SLOT_BITS-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/cal_cfg_latch.sv
// Module: cal_cfg_latch
// Decodes the raw trim inputs into a window selection and a trim count with the
// ignored low bits cleared, and holds that setting for a whole window.
// Assumes load_i pulses on the last cycle of each window.
module cal_cfg_latch
    import smooth_cal_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SLOT_BITS-1:0] calm_i,
    input  logic                 plus_i,
    input  logic                 win8_i,
    input  logic                 win16_i,
    input  logic                 load_i,
    output cal_cfg_t             cfg_o
);

    cal_cfg_t cfg_next;
    cal_cfg_t cfg_q;

    // Decode the selection (quarter wins over half) and clear the bits the window ignores.
    always_comb begin
        cfg_next.plus = plus_i;
        cfg_next.calm = calm_i;
        if (win8_i) begin
            cfg_next.sel       = WIN_QUARTER;
            cfg_next.calm[1:0] = 2'b00;
        end else if (win16_i) begin
            cfg_next.sel     = WIN_HALF;
            cfg_next.calm[0] = 1'b0;
        end else begin
            cfg_next.sel = WIN_FULL;
        end
    end

    // Capture the decoded setting only on a window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load_i) begin
            cfg_q <= cfg_next;
        end
    end

    assign cfg_o = cfg_q;

    // R9: the active setting moves only at a boundary.
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(cfg_q));
    // R8: the selection never takes the unused code.
    assert_sel_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.sel != 2'd3);
    // R6: the half window carries an even count.
    assert_half_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.sel == WIN_HALF) |-> (cfg_q.calm[0] == 1'b0));
    // R7: the quarter window carries a count that is a multiple of four.
    assert_quarter_lsbs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.sel == WIN_QUARTER) |-> (cfg_q.calm[1:0] == 2'b00));

endmodule

// File: rtl/cal_win_ctr.sv
// Module: cal_win_ctr
// Counts reference cycles through a window whose length is 2^WIN_LOG2 shifted
// right by the selection code, and flags the last cycle of the window.
// Assumes the selection changes only together with the wrap.
module cal_win_ctr
    import smooth_cal_pkg::*;
#(
    parameter int WIN_LOG2 = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  win_sel_e            sel_i,
    output logic [WIN_LOG2-1:0] cnt_o,
    output logic                wrap_o
);

    logic [WIN_LOG2-1:0] cnt_q;
    logic [WIN_LOG2-1:0] last_cnt;

    // Last count of the active window.
    always_comb begin
        last_cnt = {WIN_LOG2{1'b1}} >> sel_i;
    end

    assign wrap_o = (cnt_q == last_cnt);

    // Advance the count and return to zero after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wrap_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R2: the count stays inside the active window.
    assert_cnt_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_cnt);
    // R2: a new window starts at zero.
    assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0));

endmodule

// File: rtl/cal_pulse_gen.sv
// Module: cal_pulse_gen
// Decides per cycle whether the pulse is masked, doubled or passed. One decoder
// is built for each window length, and the active one is chosen by the setting.
// Assumes WIN_LOG2 - 2 >= SLOT_BITS so every window holds 512 whole slots.
module cal_pulse_gen
    import smooth_cal_pkg::*;
#(
    parameter int WIN_LOG2 = 20
) (
    input  logic [WIN_LOG2-1:0] cnt_i,
    input  cal_cfg_t            cfg_i,
    output logic [1:0]          adv_o
);

    localparam int NUM_LEN = 3;

    logic [NUM_LEN-1:0] mask_k;
    logic [NUM_LEN-1:0] ins_k;
    logic               mask_sel;
    logic               ins_sel;

    for (genvar k = 0; k < NUM_LEN; k++) begin : g_len
        localparam int LEN_LOG2 = WIN_LOG2 - k;
        localparam int SUB_W    = LEN_LOG2 - SLOT_BITS;

        logic [SLOT_BITS-1:0] slot_idx;
        logic [SLOT_BITS-1:0] slot_rev;
        logic                 slot_start;
        logic [SLOT_BITS:0]   ins_lim;
        logic [SLOT_BITS-1:0] mask_lim;

        assign slot_idx = cnt_i[LEN_LOG2-1 -: SLOT_BITS];
        assign slot_rev = bit_rev(slot_idx);
        assign ins_lim  = (SLOT_BITS + 1)'(NUM_SLOTS >> k);
        assign mask_lim = cfg_i.calm >> k;

        if (SUB_W > 0) begin : g_sub
            assign slot_start = (cnt_i[SUB_W-1:0] == '0);
        end else begin : g_nosub
            assign slot_start = 1'b1;
        end

        // Mask or insert on a slot start whose reversed index is under the limit.
        always_comb begin
            mask_k[k] = slot_start && (slot_rev < mask_lim);
            ins_k[k]  = slot_start && cfg_i.plus && ({1'b0, slot_rev} < ins_lim);
        end
    end

    // Select the decoder that matches the active window length.
    always_comb begin
        unique case (cfg_i.sel)
            WIN_FULL:    begin mask_sel = mask_k[0]; ins_sel = ins_k[0]; end
            WIN_HALF:    begin mask_sel = mask_k[1]; ins_sel = ins_k[1]; end
            WIN_QUARTER: begin mask_sel = mask_k[2]; ins_sel = ins_k[2]; end
            default:     begin mask_sel = 1'b0;      ins_sel = 1'b0;      end
        endcase
    end

    // Combine: masked-only gives 0, inserted-only gives 2, otherwise 1.
    always_comb begin
        adv_o = {ins_sel & ~mask_sel, ~(ins_sel ^ mask_sel)};
    end

endmodule

// File: rtl/smooth_cal_unit.sv
// Module: smooth_cal_unit (top)
// Removes or adds reference pulses evenly over a calibration window, to trim a
// calendar fed from a 32768 Hz clock. adv_o is the number of prescaler steps to
// take this cycle. Assumes clk is the reference clock itself.
module smooth_cal_unit
    import smooth_cal_pkg::*;
#(
    parameter int WIN_LOG2 = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [8:0] calm_i,
    input  logic       plus_i,
    input  logic       win8_i,
    input  logic       win16_i,
    output logic [1:0] adv_o
);

    cal_cfg_t            cfg;
    logic [WIN_LOG2-1:0] cnt;
    logic                wrap;
    logic [1:0]          adv;

    cal_cfg_latch u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .calm_i  (calm_i),
        .plus_i  (plus_i),
        .win8_i  (win8_i),
        .win16_i (win16_i),
        .load_i  (wrap),
        .cfg_o   (cfg)
    );

    cal_win_ctr #(.WIN_LOG2(WIN_LOG2)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (cfg.sel),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    cal_pulse_gen #(.WIN_LOG2(WIN_LOG2)) u_gen (
        .cnt_i (cnt),
        .cfg_i (cfg),
        .adv_o (adv)
    );

    assign adv_o = adv;

    // R5: the advance code 3 is never produced.
    assert_adv_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o != 2'd3);
    // R4: a double step happens only while insertion is enabled.
    assert_ins_needs_plus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o == 2'd2) |-> cfg.plus);
    // R3: pulses are never removed while the count is zero.
    assert_no_mask_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.calm == '0) |-> (adv_o != 2'd0));
    // R1: the cycle after reset is a plain step.
    assert_reset_plain_R1: assert property (@(posedge clk)
        !rst_n |=> (adv_o == 2'd1));

endmodule

// File: tb/smooth_cal_unit_tb.sv
`timescale 1ns/1ps
module smooth_cal_unit_tb_top;

    localparam int N    = 12;
    localparam int FULL = 1 << N;
    localparam int NV   = 12;

    // Table: count, plus, quarter select, half select, expected sum of window 1.
    localparam int V_CALM [NV] = '{0,    1,    256,  511,  0,    511,  3,    301,  7,    511,  100,  200};
    localparam int V_PLUS [NV] = '{0,    0,    0,    0,    1,    1,    0,    1,    0,    1,    0,    0};
    localparam int V_W8   [NV] = '{0,    0,    0,    0,    0,    0,    0,    0,    1,    1,    1,    0};
    localparam int V_W16  [NV] = '{0,    0,    0,    0,    0,    0,    1,    1,    0,    0,    1,    1};
    localparam int V_LEN  [NV] = '{4096, 4096, 4096, 4096, 4096, 4096, 2048, 2048, 1024, 1024, 1024, 2048};
    localparam int V_EXP  [NV] = '{4096, 4095, 3840, 3585, 4608, 4097, 2047, 2154, 1023, 1025, 999,  1948};
    // rows 0-3: R2, rows 4-5: R4/R5, rows 6-7 and 11: R6, rows 8-9: R7, row 10: R8

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] calm_i = '0;
    logic       plus_i = 1'b0;
    logic       win8_i = 1'b0;
    logic       win16_i = 1'b0;
    logic [1:0] adv_o;

    int checks = 0;
    int errors = 0;

    smooth_cal_unit #(.WIN_LOG2(N)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .calm_i  (calm_i),
        .plus_i  (plus_i),
        .win8_i  (win8_i),
        .win16_i (win16_i),
        .adv_o   (adv_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reset, then leave the bench at the negedge that shows cycle 0.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Sum adv_o over n cycles, sampling at negedges; counts the 0 and 2 codes.
    task automatic sum_cycles(input int n, output int s, output int n0, output int n2);
        s = 0; n0 = 0; n2 = 0;
        for (int i = 0; i < n; i++) begin
            s += int'(adv_o);
            if (adv_o == 2'd0) n0++;
            if (adv_o == 2'd2) n2++;
            @(negedge clk);
        end
    endtask

    task automatic set_cfg(input int c, input int p, input int w8, input int w16);
        calm_i  = 9'(c);
        plus_i  = p[0];
        win8_i  = w8[0];
        win16_i = w16[0];
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s, n0, n2;
        string tag;

        // Table walk: first window is untrimmed, second follows the table row.
        for (int v = 0; v < NV; v++) begin
            set_cfg(V_CALM[v], V_PLUS[v], V_W8[v], V_W16[v]);
            do_reset();
            chk(adv_o == 2'd1, "R1 reset output", int'(adv_o), 1);
            sum_cycles(FULL, s, n0, n2);
            chk(s == FULL, "R1 first window", s, FULL);
            sum_cycles(V_LEN[v], s, n0, n2);
            if (V_W8[v] != 0 && V_W16[v] != 0) tag = "R8";
            else if (V_W8[v] != 0)             tag = "R7";
            else if (V_W16[v] != 0)            tag = "R6";
            else if (V_PLUS[v] != 0)           tag = "R4";
            else                               tag = "R2";
            chk(s == V_EXP[v], tag, s, V_EXP[v]);
        end

        // R3: spreading - half the full window holds half the masks.
        set_cfg(256, 0, 0, 0);
        do_reset();
        sum_cycles(FULL, s, n0, n2);
        sum_cycles(FULL / 2, s, n0, n2);
        chk(s == FULL / 2 - 128, "R3 first half sum", s, FULL / 2 - 128);
        chk(n0 == 128, "R3 first half masks", n0, 128);

        // R5: overlap of removal and insertion.
        set_cfg(511, 1, 0, 0);
        do_reset();
        sum_cycles(FULL, s, n0, n2);
        sum_cycles(FULL, s, n0, n2);
        chk(n2 == 1, "R5 double steps", n2, 1);
        chk(n0 == 0, "R5 masked cycles", n0, 0);
        chk(s == FULL + 1, "R5 window sum", s, FULL + 1);

        // R9: a change inside a window waits for the boundary.
        set_cfg(0, 0, 1, 0);
        do_reset();
        sum_cycles(FULL, s, n0, n2);
        begin
            int s1, s2;
            sum_cycles(10, s1, n0, n2);
            plus_i = 1'b1;
            sum_cycles(1014, s2, n0, n2);
            chk(s1 + s2 == 1024, "R9 window with mid change", s1 + s2, 1024);
        end
        sum_cycles(1024, s, n0, n2);
        chk(s == 1152, "R9 next window", s, 1152);

        // R1: reset in mid-run clears the active setting.
        do_reset();
        chk(adv_o == 2'd1, "R1 mid-run reset output", int'(adv_o), 1);
        sum_cycles(FULL, s, n0, n2);
        chk(s == FULL, "R1 window after reset ignores plus", s, FULL);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule